// File: doc/BRIEF.md
# Burst-Rate Flit Injection Regulator

This block sits in front of a network-on-chip injection port and shapes the traffic of several flows so that each flow obeys a (burst, rate) arrival curve. Over any window of length T cycles, a flow configured with burst `sigma` and rate `rho` can inject no more than about sigma + rho·T/256 flits. The budget is counted in flits, never in packets, because the network link moves one 32-bit flit per cycle.

Each flow has a credit bucket in fixed point with eight fraction bits. Every cycle the bucket gains `rho`/256 of a flit and is capped at `sigma` whole flits. Each injected flit costs one whole credit. A flow whose bucket holds less than one flit is held back by keeping its ready low. Among the flows that have a flit waiting and the credit to send it, a round-robin selector picks one. Once the head flit of a multi-flit packet has gone out, the port stays with that flow until the tail flit has gone out. This keeps wormhole packets contiguous on the link.

Software programs `sigma` and `rho` one flow at a time through a single write strobe. A write reloads the flow's bucket to its full burst.

Top module: `br_flit_regulator`

## Requirements
- R1: After reset every flow has sigma = 0 and rho = 0 and an empty bucket, so no flow is forwarded: `inj_valid` and all `src_ready` bits stay low even while sources present flits.
- R2: A cycle with `cfg_we` high stores `cfg_sigma` and `cfg_rho` for flow `cfg_flow` and loads that flow's bucket with `cfg_sigma` whole flits. From the following cycle the flow can send a burst of that size, even if its bucket was empty before.
- R3: A flow is forwarded only while its bucket holds at least one whole flit. With rho = 0 a flow sends exactly sigma flits and then stalls with its flits still pending.
- R4: The bucket gains rho/256 flit per cycle and loses exactly one flit per accepted flit. With sigma = 1 and rho = 64, a flow with a steady backlog sends one flit every 4 cycles.
- R5: The bucket never exceeds sigma flits, however long the flow stays idle. With sigma = 2 and rho = 128, a backlog that arrives after a long idle time leaves with gaps of 1, 1, 2, 2, 2 cycles.
- R6: When the port is not held by a packet, the grant goes to the first eligible flow (valid and with credit) after the flow that last finished a packet, in cyclic index order. With four flows always eligible and sending one-flit packets, the flow index advances by one (mod 4) at each transfer.
- R7: After a flit with `src_last` low is accepted, the same flow keeps the port until its flit with `src_last` high is accepted, so the flits of one packet are never interleaved with those of another flow.
- R8: While a packet holds the port and its flow lacks credit, no other flow is granted, even if it is eligible.
- R9: `inj_valid` does not depend on `inj_ready`. `src_ready` is high only for the granted flow and only while `inj_ready` is high. `inj_data`, `inj_last` and `inj_flow` are the granted flow's flit, its last marker and its index. No credit is spent in a cycle without a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_flow | input | FLOW_W | Flow written by `cfg_we` |
| cfg_sigma | input | 8 | Burst size in whole flits |
| cfg_rho | input | 8 | Rate in 1/256 flit per cycle |
| src_valid | input | N_FLOWS | Per-flow flit valid |
| src_last | input | N_FLOWS | Per-flow tail-of-packet marker |
| src_data | input | N_FLOWS*DATA_W | Per-flow flit data, flow f at bits f*DATA_W upward |
| src_ready | output | N_FLOWS | Per-flow accept |
| inj_valid | output | 1 | Flit offered to the network |
| inj_ready | input | 1 | Network accepts the flit |
| inj_data | output | DATA_W | Injected flit |
| inj_last | output | 1 | Injected flit ends its packet |
| inj_flow | output | FLOW_W | Index of the injected flow |

## Verification
The assertions check on every cycle the local rules of the block: a bucket never goes above its cap, no flit is taken without a whole credit, a bucket never drops unless a flit is taken, a write reloads the bucket, the grant is one-hot and backed by a request, and a held port never goes to another flow. The long-run consequences can only be shown by the bench scenarios, which watch handshakes at the ports and compare them with values worked out by hand from the requirements. These are the exact burst size, the spacing set by the rate, the gap pattern after saturation, the rotation order and the contiguity of packets.

// File: rtl/br_reg_pkg.sv
package br_reg_pkg;

  localparam int RATE_W  = 8;
  localparam int BURST_W = 8;
  localparam int FRAC_W  = RATE_W;
  localparam int CRED_W  = BURST_W + FRAC_W;

  typedef logic [RATE_W-1:0]  rate_t;
  typedef logic [BURST_W-1:0] burst_t;
  typedef logic [CRED_W-1:0]  credit_t;

  typedef struct packed {
    burst_t sigma;
    rate_t  rho;
  } flow_cfg_t;

  localparam credit_t ONE_FLIT = credit_t'(1) << FRAC_W;

  // Burst size expressed in fixed-point credit units.
  function automatic credit_t credit_cap(burst_t s);
    return {s, {FRAC_W{1'b0}}};
  endfunction

  // A flow may send when at least one whole flit is banked.
  function automatic logic has_flit(credit_t c);
    return c >= ONE_FLIT;
  endfunction

  // One cycle of bucket arithmetic: earn rho, pay one flit if taken, clip at the cap.
  function automatic credit_t credit_next(credit_t cur, flow_cfg_t cfg, logic take);
    logic [CRED_W:0] sum;
    logic [CRED_W:0] cap;
    sum = {1'b0, cur} + {{(CRED_W + 1 - RATE_W){1'b0}}, cfg.rho};
    if (take) sum = sum - {1'b0, ONE_FLIT};
    cap = {1'b0, credit_cap(cfg.sigma)};
    if (sum > cap) return credit_cap(cfg.sigma);
    return sum[CRED_W-1:0];
  endfunction

endpackage

// File: rtl/br_credit_bucket.sv
module br_credit_bucket
  import br_reg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_hit,
  input  flow_cfg_t cfg_in,
  input  logic      take,
  output logic      eligible
);

  flow_cfg_t cfg_q;
  credit_t   credit_q;
  credit_t   credit_d;
  burst_t    sigma_in;

  assign sigma_in = cfg_in.sigma;

  always_comb credit_d = credit_next(credit_q, cfg_q, take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      credit_q <= '0;
    end else if (cfg_hit) begin
      cfg_q    <= cfg_in;
      credit_q <= credit_cap(cfg_in.sigma);
    end else begin
      credit_q <= credit_d;
    end
  end

  assign eligible = has_flit(credit_q);

  // R5: the bank never holds more than the burst size
  a_r5_credit_cap: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= credit_cap(cfg_q.sigma));

  // R3: a flit is only taken against a whole credit
  a_r3_take_needs_flit: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> eligible);

  // R4/R9: without a transfer the bank never shrinks
  a_r4_idle_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !cfg_hit) |=> credit_q >= $past(credit_q));

  // R4: a transfer always lowers the bank, since rho is below one flit
  a_r4_take_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_hit) |=> credit_q < $past(credit_q));

  // R2: a parameter write refills the bank to the new burst
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> credit_q == credit_cap($past(sigma_in)));

endmodule

// File: rtl/br_rr_lock.sv
module br_rr_lock #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    last_in,
  input  logic            fire,
  output logic [N-1:0]    grant,
  output logic [ID_W-1:0] grant_id
);

  logic            lock_q;
  logic [ID_W-1:0] lock_id_q;
  logic [ID_W-1:0] ptr_q;
  logic [N-1:0]    lock_mask;
  logic            pkt_end;

  function automatic logic [N-1:0] rr_pick(logic [N-1:0] r, logic [ID_W-1:0] p);
    logic [N-1:0] pick;
    pick = '0;
    for (int k = 1; k <= N; k++) begin
      int idx = (int'(p) + k) % N;
      if (pick == '0 && r[idx]) pick[idx] = 1'b1;
    end
    return pick;
  endfunction

  function automatic logic [ID_W-1:0] to_id(logic [N-1:0] oh);
    logic [ID_W-1:0] id;
    id = '0;
    for (int k = 0; k < N; k++) begin
      if (oh[k]) id = id | ID_W'(k);
    end
    return id;
  endfunction

  assign lock_mask = N'(1) << lock_id_q;

  always_comb begin
    if (lock_q) grant = req & lock_mask;
    else        grant = rr_pick(req, ptr_q);
  end

  assign grant_id = to_id(grant);
  assign pkt_end  = last_in[grant_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      lock_id_q <= '0;
      ptr_q     <= ID_W'(N - 1);
    end else if (fire) begin
      if (pkt_end) begin
        lock_q <= 1'b0;
        ptr_q  <= grant_id;
      end else begin
        lock_q    <= 1'b1;
        lock_id_q <= grant_id;
      end
    end
  end

  // R9: at most one flow owns the port
  a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: a grant always goes to a requesting flow
  a_r6_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  // R6: an unheld port with any request is never left idle
  a_r6_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && (req != '0)) |-> (grant != '0));

  // R7: a non-tail transfer holds the port
  a_r7_lock_after_head: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pkt_end) |=> lock_q);

  // R8: a held port is never handed to another flow
  a_r8_lock_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> ((grant & ~lock_mask) == '0));

endmodule

// File: rtl/br_flit_regulator.sv
module br_flit_regulator
  import br_reg_pkg::*;
#(
  parameter  int N_FLOWS = 4,
  parameter  int DATA_W  = 32,
  localparam int FLOW_W  = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [FLOW_W-1:0]         cfg_flow,
  input  logic [BURST_W-1:0]        cfg_sigma,
  input  logic [RATE_W-1:0]         cfg_rho,
  input  logic [N_FLOWS-1:0]        src_valid,
  input  logic [N_FLOWS-1:0]        src_last,
  input  logic [N_FLOWS*DATA_W-1:0] src_data,
  output logic [N_FLOWS-1:0]        src_ready,
  output logic                      inj_valid,
  input  logic                      inj_ready,
  output logic [DATA_W-1:0]         inj_data,
  output logic                      inj_last,
  output logic [FLOW_W-1:0]         inj_flow
);

  flow_cfg_t          cfg_word;
  logic [N_FLOWS-1:0] eligible;
  logic [N_FLOWS-1:0] req;
  logic [N_FLOWS-1:0] grant;
  logic [FLOW_W-1:0]  grant_id;
  logic               fire;

  assign cfg_word.sigma = cfg_sigma;
  assign cfg_word.rho   = cfg_rho;

  for (genvar f = 0; f < N_FLOWS; f++) begin : g_flow
    logic hit;
    assign hit = cfg_we && (cfg_flow == FLOW_W'(f));
    br_credit_bucket u_bucket (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_hit  (hit),
      .cfg_in   (cfg_word),
      .take     (src_ready[f]),
      .eligible (eligible[f])
    );
  end

  assign req = src_valid & eligible;

  br_rr_lock #(.N(N_FLOWS), .ID_W(FLOW_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .last_in  (src_last),
    .fire     (fire),
    .grant    (grant),
    .grant_id (grant_id)
  );

  assign inj_valid = |grant;
  assign inj_flow  = grant_id;
  assign inj_data  = src_data[grant_id*DATA_W +: DATA_W];
  assign inj_last  = src_last[grant_id];
  assign src_ready = grant & {N_FLOWS{inj_ready}};
  assign fire      = inj_valid && inj_ready;

  // R9: a source is only accepted alongside a network transfer
  a_r9_ready_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready != '0) |-> (inj_valid && inj_ready));

  // R9: the offered flit belongs to a flow that presents one
  a_r9_offer_backed: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> src_valid[inj_flow]);

endmodule

// File: tb/tb_br_flit_regulator.sv
`timescale 1ns/1ps
module tb_br_flit_regulator;

  localparam int NF = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_flow;
  logic [7:0]       cfg_sigma;
  logic [7:0]       cfg_rho;
  logic [NF-1:0]    src_valid;
  logic [NF-1:0]    src_last;
  logic [NF*DW-1:0] src_data;
  logic [NF-1:0]    src_ready;
  logic             inj_valid;
  logic             inj_ready;
  logic [DW-1:0]    inj_data;
  logic             inj_last;
  logic [1:0]       inj_flow;

  br_flit_regulator #(.N_FLOWS(NF), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flow(cfg_flow),
    .cfg_sigma(cfg_sigma), .cfg_rho(cfg_rho), .src_valid(src_valid),
    .src_last(src_last), .src_data(src_data), .src_ready(src_ready),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_data(inj_data),
    .inj_last(inj_last), .inj_flow(inj_flow)
  );

  logic [DW:0] src_q [NF][$];
  logic [DW:0] exp_q [NF][$];
  int fire_cnt [NF];
  int fire_cyc [NF][16];
  int seq_flow [64];
  int nseq;
  int cyc;
  int n_cmp;
  int n_bad;
  int seq_no;

  task automatic check_eq(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int f = 0; f < NF; f++) fire_cnt[f] = 0;
    nseq = 0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cfg_write(int f, int s, int r);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_flow = 2'(f); cfg_sigma = 8'(s); cfg_rho = 8'(r);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_ready(logic v);
    @(posedge clk); #1;
    inj_ready = v;
  endtask

  task automatic push_pkt(int f, int len);
    @(posedge clk); #2;
    for (int i = 0; i < len; i++) begin
      logic [DW:0] w;
      w = {(i == len - 1), 8'(f), 24'(seq_no)};
      seq_no++;
      src_q[f].push_back(w);
      exp_q[f].push_back(w);
    end
  endtask

  // Scoreboard monitor and source driver
  initial begin
    src_valid = '0; src_last = '0; src_data = '0;
    forever begin
      logic fired;
      int   ff;
      logic [DW:0] e;
      logic [NF-1:0] exp_rdy;
      @(negedge clk);
      cyc++;
      fired = 1'b0;
      ff = 0;
      if (rst_n) begin
        fired = inj_valid && inj_ready;
        ff = int'(inj_flow);
        exp_rdy = fired ? (NF'(1) << ff) : '0;
        check_eq("R9 src_ready vector", int'(src_ready), int'(exp_rdy));
        if (fired) begin
          if (exp_q[ff].size() == 0) begin
            check_eq("R9 unexpected flit from flow", ff, -1);
          end else begin
            e = exp_q[ff].pop_front();
            check_eq("R9 inj_data", int'(inj_data), int'(e[DW-1:0]));
            check_eq("R9 inj_last", int'(inj_last), int'(e[DW]));
          end
          if (fire_cnt[ff] < 16) fire_cyc[ff][fire_cnt[ff]] = cyc;
          fire_cnt[ff]++;
          if (nseq < 64) seq_flow[nseq] = ff;
          nseq++;
        end
      end
      @(posedge clk); #1;
      if (fired && src_q[ff].size() > 0) void'(src_q[ff].pop_front());
      for (int f = 0; f < NF; f++) begin
        if (src_q[f].size() > 0) begin
          src_valid[f] = 1'b1;
          src_last[f]  = src_q[f][0][DW];
          src_data[f*DW +: DW] = src_q[f][0][DW-1:0];
        end else begin
          src_valid[f] = 1'b0;
          src_last[f]  = 1'b0;
          src_data[f*DW +: DW] = '0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; seq_no = 0; nseq = 0;
    for (int f = 0; f < NF; f++) fire_cnt[f] = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_flow = '0; cfg_sigma = '0; cfg_rho = '0;
    inj_ready = 1'b1;
    for (int i = 0; i < 2; i++) begin
      src_q[0].push_back({1'b1, 8'd0, 24'(seq_no)}); exp_q[0].push_back({1'b1, 8'd0, 24'(seq_no)}); seq_no++;
      src_q[1].push_back({1'b1, 8'd1, 24'(seq_no)}); exp_q[1].push_back({1'b1, 8'd1, 24'(seq_no)}); seq_no++;
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: nothing moves out of reset
    run(20);
    check_eq("R1 inj_valid after reset", int'(inj_valid), 0);
    check_eq("R1 src_ready after reset", int'(src_ready), 0);
    check_eq("R1 flow0 sent", fire_cnt[0], 0);
    check_eq("R1 flow1 sent", fire_cnt[1], 0);

    // R3: burst of three with rho zero
    push_pkt(0, 1); push_pkt(0, 1); push_pkt(0, 1);
    cfg_write(0, 3, 0);
    run(20);
    check_eq("R3 flits sent on burst 3", fire_cnt[0], 3);
    check_eq("R3 flits left pending", src_q[0].size(), 2);
    check_eq("R3 stalled inj_valid", int'(inj_valid), 0);
    check_eq("R1 flow1 still idle", fire_cnt[1], 0);

    // R2: rewriting refills the bucket
    cfg_write(0, 2, 0);
    run(20);
    check_eq("R2 total after refill", fire_cnt[0], 5);
    check_eq("R2 queue drained", src_q[0].size(), 0);

    // R4: one flit every 4 cycles at rho 64
    clear_log();
    push_pkt(1, 1); push_pkt(1, 1); push_pkt(1, 1); push_pkt(1, 1); push_pkt(1, 1);
    cfg_write(1, 1, 64);
    run(40);
    check_eq("R4 flits sent", fire_cnt[1], 7);
    for (int i = 0; i < 6; i++)
      check_eq("R4 spacing", fire_cyc[1][i+1] - fire_cyc[1][i], 4);

    // R5: capped bank after idle time
    clear_log();
    cfg_write(2, 2, 128);
    run(50);
    for (int i = 0; i < 6; i++) push_pkt(2, 1);
    run(30);
    check_eq("R5 flits sent", fire_cnt[2], 6);
    check_eq("R5 gap 1", fire_cyc[2][1] - fire_cyc[2][0], 1);
    check_eq("R5 gap 2", fire_cyc[2][2] - fire_cyc[2][1], 1);
    check_eq("R5 gap 3", fire_cyc[2][3] - fire_cyc[2][2], 2);
    check_eq("R5 gap 4", fire_cyc[2][4] - fire_cyc[2][3], 2);
    check_eq("R5 gap 5", fire_cyc[2][5] - fire_cyc[2][4], 2);

    // R9: back-pressure spends no credit
    clear_log();
    set_ready(1'b0);
    cfg_write(3, 2, 0);
    push_pkt(3, 1); push_pkt(3, 1);
    run(10);
    check_eq("R9 valid while not ready", int'(inj_valid), 1);
    check_eq("R9 offered flow", int'(inj_flow), 3);
    check_eq("R9 no accept while not ready", int'(src_ready), 0);
    check_eq("R9 nothing sent", fire_cnt[3], 0);
    set_ready(1'b1);
    run(20);
    check_eq("R9 burst intact after stall", fire_cnt[3], 2);

    // R6: strict rotation with all flows eligible
    set_ready(1'b0);
    for (int f = 0; f < NF; f++) cfg_write(f, 255, 255);
    for (int f = 0; f < NF; f++) begin push_pkt(f, 1); push_pkt(f, 1); end
    run(2);
    clear_log();
    set_ready(1'b1);
    run(30);
    check_eq("R6 transfers", nseq, 8);
    for (int i = 0; i < 7; i++)
      check_eq("R6 rotation", seq_flow[i+1], (seq_flow[i] + 1) % NF);

    // R7: packets stay contiguous
    set_ready(1'b0);
    push_pkt(0, 3); push_pkt(1, 3);
    run(2);
    clear_log();
    set_ready(1'b1);
    run(20);
    check_eq("R7 transfers", nseq, 6);
    check_eq("R7 first packet flit 2", seq_flow[1], seq_flow[0]);
    check_eq("R7 first packet flit 3", seq_flow[2], seq_flow[0]);
    check_eq("R7 second packet flit 2", seq_flow[4], seq_flow[3]);
    check_eq("R7 second packet flit 3", seq_flow[5], seq_flow[3]);
    check_eq("R7 packets differ", int'(seq_flow[0] != seq_flow[3]), 1);

    // R8: a starved held port is not handed over
    set_ready(1'b0);
    cfg_write(2, 1, 32);
    run(10);
    push_pkt(2, 3); push_pkt(3, 1); push_pkt(3, 1);
    run(2);
    clear_log();
    set_ready(1'b1);
    run(40);
    check_eq("R8 transfers", nseq, 5);
    check_eq("R8 head", seq_flow[0], 2);
    check_eq("R8 body", seq_flow[1], 2);
    check_eq("R8 tail", seq_flow[2], 2);
    check_eq("R8 other after tail", seq_flow[3], 3);
    check_eq("R8 other second", seq_flow[4], 3);
    check_eq("R8 starved gap 1", fire_cyc[2][1] - fire_cyc[2][0], 8);
    check_eq("R8 starved gap 2", fire_cyc[2][2] - fire_cyc[2][1], 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule